// File: doc/BRIEF.md
# Dual-Port Shared-Array RAM with Per-Port Aspect Ratio

This block is a true dual-port synchronous RAM holding 16,384 data bits and 2,048 parity bits, 18,432 bits in all. Each of its two ports picks its own depth-by-width shape through a parameter. Both ports see one common bit array, so a word written through a narrow port can be read back as part of a wide word through the other port, and the reverse. Parity bits exist only for the byte-based shapes, one parity bit beside every data byte.

Both ports share one clock. Either port may read, write or idle in any cycle, independent of the other. Reads and writes take effect at the clock edge, and the output register of a port updates one edge after the request. On a write, the output of the writing port shows the data just written. When both ports write different bits of the same storage row in one cycle, both writes land. When both write the same bits in one cycle, the result is undefined and the design flags it.

Top module: `tdp_shape_ram`

## Requirements
- R1: A port of width W must be one of 1, 2, 4, 9, 18 or 36. It carries W data bits when W is below 9, and otherwise 8*W/9 data bits plus W/9 parity bits. Its address width is log2(16384 / data bits), giving 14, 13, 12, 11, 10 or 9 bits. On the 1-, 2- and 4-bit shapes the parity output always reads 0.
- R2: A cycle with enable 1 and write-enable 0 loads the addressed word into the port's data and parity outputs at that edge, so the outputs show the word one cycle after the request.
- R3: A cycle with enable 1 and write-enable 1 stores the data (and parity, where present) at the address. At the same edge the port's outputs take the written values (write-first).
- R4: A cycle with enable 0 writes nothing and leaves that port's outputs unchanged, whatever write-enable, address and data hold.
- R5: Data bit b of word n on a port with D data bits is shared data bit n*D+b. A byte written on a 9-bit port at address n therefore appears as bits [8*(n mod 4)+7 : 8*(n mod 4)] of word n/4 on a 36-bit port.
- R6: Parity bit p of word n on a port with P parity bits is shared parity bit n*P+p. The parity bit of 9-bit word n is bit (n mod 4) of the parity of 36-bit word n/4.
- R7: In one cycle both ports may write. Writes to disjoint bits both take effect, including disjoint bits of the same 32-bit storage row. Writes that overlap are unsupported and are flagged.
- R8: A port that reads bits the other port writes in the same cycle returns the contents from before that write.
- R9: While reset is low, both ports' data and parity outputs are 0. Reset does not clear stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low reset of the output registers |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable (used when en_a is 1) |
| addr_a | input | AW_A | Port A word address |
| din_a | input | DW_A | Port A write data |
| pin_a | input | PP_A | Port A write parity (ignored on narrow shapes) |
| dout_a | output | DW_A | Port A registered data output |
| pout_a | output | PP_A | Port A registered parity output |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable (used when en_b is 1) |
| addr_b | input | AW_B | Port B word address |
| din_b | input | DW_B | Port B write data |
| pin_b | input | PP_B | Port B write parity (ignored on narrow shapes) |
| dout_b | output | DW_B | Port B registered data output |
| pout_b | output | PP_B | Port B registered parity output |

## Verification
The assertions check these rules on every cycle for each port:
- write-first output;
- outputs held while the port is idle;
- a write followed by a read of the same address on the same port returns the written data;
- no overlapping write from the two ports in the same cycle.

The bench scenarios cover what depends on how the two views of the array line up:
- byte and parity placement across a 9-bit and a 36-bit port;
- merging of same-row writes from a 2-bit and a 4-bit port;
- old-data return when one port reads a row the other is writing;
- parity reading 0 on narrow shapes.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
   localparam int DATA_BITS = 16384;
   localparam int PAR_BITS  = 2048;
   localparam int ROW_D     = 32;
   localparam int ROW_P     = 4;
   localparam int ROWS      = DATA_BITS / ROW_D;
   localparam int ROW_AW    = $clog2(ROWS);

   function automatic bit shape_ok(input int w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
   endfunction

   function automatic int data_w(input int w);
      return (w >= 9) ? (w / 9) * 8 : w;
   endfunction

   function automatic int par_w(input int w);
      return (w >= 9) ? (w / 9) : 0;
   endfunction

   function automatic int addr_w(input int w);
      return $clog2(DATA_BITS / data_w(w));
   endfunction
endpackage

// File: rtl/tdp_port_map.sv
module tdp_port_map
   import tdp_pkg::*;
#(
   parameter  int WIDTH = 9,
   localparam int DW    = data_w(WIDTH),
   localparam int PW    = par_w(WIDTH),
   localparam int PP    = (PW > 0) ? PW : 1,
   localparam int AW    = addr_w(WIDTH)
) (
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     din,
   input  logic [PP-1:0]     pin,
   input  logic [ROW_D-1:0]  drow,
   input  logic [ROW_P-1:0]  prow,
   output logic [ROW_AW-1:0] row,
   output logic [ROW_D-1:0]  dmask,
   output logic [ROW_D-1:0]  dbits,
   output logic [ROW_P-1:0]  pmask,
   output logic [ROW_P-1:0]  pbits,
   output logic [DW-1:0]     rdata,
   output logic [PP-1:0]     rpar,
   output logic [PP-1:0]     wpar
);
   localparam int DSLOTS = ROW_D / DW;
   localparam logic [ROW_D-1:0] DONES = (DW == ROW_D) ? '1 : ROW_D'((64'd1 << DW) - 64'd1);

   if (!shape_ok(WIDTH)) begin : g_bad_shape
      $error("tdp_port_map: WIDTH %0d is not a supported shape", WIDTH);
   end

   logic [4:0] doff;

   assign row = addr[AW-1 -: ROW_AW];

   if (DSLOTS > 1) begin : g_dslot
      assign doff = 5'(int'(addr[$clog2(DSLOTS)-1:0]) * DW);
   end else begin : g_dfull
      assign doff = 5'd0;
   end

   assign dmask = DONES << doff;
   assign dbits = ROW_D'(din) << doff;
   assign rdata = DW'(drow >> doff);

   if (PW > 0) begin : g_par
      localparam int PSLOTS = ROW_P / PW;
      localparam logic [ROW_P-1:0] PONES = (PW == ROW_P) ? '1 : ROW_P'((32'd1 << PW) - 32'd1);
      logic [1:0] poff;
      if (PSLOTS > 1) begin : g_pslot
         assign poff = 2'(int'(addr[$clog2(PSLOTS)-1:0]) * PW);
      end else begin : g_pfull
         assign poff = 2'd0;
      end
      assign pmask = PONES << poff;
      assign pbits = ROW_P'(pin) << poff;
      assign rpar  = PP'(prow >> poff);
      assign wpar  = pin;
   end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^{pin, prow};
      assign pmask = '0;
      assign pbits = '0;
      assign rpar  = '0;
      assign wpar  = '0;
   end
endmodule

// File: rtl/tdp_out_reg.sv
module tdp_out_reg #(
   parameter int DW = 8,
   parameter int PP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   input  logic [PP-1:0] wpar,
   input  logic [DW-1:0] rdata,
   input  logic [PP-1:0] rpar,
   output logic [DW-1:0] dout,
   output logic [PP-1:0] pout
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= '0;
         pout <= '0;
      end else if (en) begin
         dout <= we ? wdata : rdata;
         pout <= we ? wpar  : rpar;
      end
   end
endmodule

// File: rtl/tdp_shape_ram.sv
module tdp_shape_ram
   import tdp_pkg::*;
#(
   parameter  int WIDTH_A = 9,
   parameter  int WIDTH_B = 36,
   localparam int DW_A    = data_w(WIDTH_A),
   localparam int PP_A    = (par_w(WIDTH_A) > 0) ? par_w(WIDTH_A) : 1,
   localparam int AW_A    = addr_w(WIDTH_A),
   localparam int DW_B    = data_w(WIDTH_B),
   localparam int PP_B    = (par_w(WIDTH_B) > 0) ? par_w(WIDTH_B) : 1,
   localparam int AW_B    = addr_w(WIDTH_B)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_a,
   input  logic            we_a,
   input  logic [AW_A-1:0] addr_a,
   input  logic [DW_A-1:0] din_a,
   input  logic [PP_A-1:0] pin_a,
   output logic [DW_A-1:0] dout_a,
   output logic [PP_A-1:0] pout_a,
   input  logic            en_b,
   input  logic            we_b,
   input  logic [AW_B-1:0] addr_b,
   input  logic [DW_B-1:0] din_b,
   input  logic [PP_B-1:0] pin_b,
   output logic [DW_B-1:0] dout_b,
   output logic [PP_B-1:0] pout_b
);
   logic [ROW_D-1:0] mem_d [ROWS];
   logic [ROW_P-1:0] mem_p [ROWS];

   logic [ROW_AW-1:0] row_a, row_b;
   logic [ROW_D-1:0]  dmask_a, dbits_a, dmask_b, dbits_b;
   logic [ROW_P-1:0]  pmask_a, pbits_a, pmask_b, pbits_b;
   logic [ROW_D-1:0]  drow_a, drow_b;
   logic [ROW_P-1:0]  prow_a, prow_b;
   logic [DW_A-1:0]   rdata_a;
   logic [DW_B-1:0]   rdata_b;
   logic [PP_A-1:0]   rpar_a, wpar_a;
   logic [PP_B-1:0]   rpar_b, wpar_b;

   assign drow_a = mem_d[row_a];
   assign prow_a = mem_p[row_a];
   assign drow_b = mem_d[row_b];
   assign prow_b = mem_p[row_b];

   tdp_port_map #(.WIDTH(WIDTH_A)) u_map_a (
      .addr(addr_a), .din(din_a), .pin(pin_a), .drow(drow_a), .prow(prow_a),
      .row(row_a), .dmask(dmask_a), .dbits(dbits_a), .pmask(pmask_a), .pbits(pbits_a),
      .rdata(rdata_a), .rpar(rpar_a), .wpar(wpar_a)
   );

   tdp_port_map #(.WIDTH(WIDTH_B)) u_map_b (
      .addr(addr_b), .din(din_b), .pin(pin_b), .drow(drow_b), .prow(prow_b),
      .row(row_b), .dmask(dmask_b), .dbits(dbits_b), .pmask(pmask_b), .pbits(pbits_b),
      .rdata(rdata_b), .rpar(rpar_b), .wpar(wpar_b)
   );

   logic wr_a, wr_b, same_row;
   logic [ROW_D-1:0] nd_a, nd_b;
   logic [ROW_P-1:0] np_a, np_b;

   assign wr_a     = en_a & we_a;
   assign wr_b     = en_b & we_b;
   assign same_row = (row_a == row_b);

   // Each port's new row value folds in the other port's bits when both write one row.
   always_comb begin
      nd_a = (drow_a & ~dmask_a) | dbits_a;
      np_a = (prow_a & ~pmask_a) | pbits_a;
      if (wr_b && same_row) begin
         nd_a = (nd_a & ~dmask_b) | dbits_b;
         np_a = (np_a & ~pmask_b) | pbits_b;
      end
      nd_b = (drow_b & ~dmask_b) | dbits_b;
      np_b = (prow_b & ~pmask_b) | pbits_b;
      if (wr_a && same_row) begin
         nd_b = (nd_b & ~dmask_a) | dbits_a;
         np_b = (np_b & ~pmask_a) | pbits_a;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_a) begin
         mem_d[row_a] <= nd_a;
         mem_p[row_a] <= np_a;
      end
      if (wr_b) begin
         mem_d[row_b] <= nd_b;
         mem_p[row_b] <= np_b;
      end
   end

   tdp_out_reg #(.DW(DW_A), .PP(PP_A)) u_out_a (
      .clk(clk), .rst_n(rst_n), .en(en_a), .we(we_a),
      .wdata(din_a), .wpar(wpar_a), .rdata(rdata_a), .rpar(rpar_a),
      .dout(dout_a), .pout(pout_a)
   );

   tdp_out_reg #(.DW(DW_B), .PP(PP_B)) u_out_b (
      .clk(clk), .rst_n(rst_n), .en(en_b), .we(we_b),
      .wdata(din_b), .wpar(wpar_b), .rdata(rdata_b), .rpar(rpar_b),
      .dout(dout_b), .pout(pout_b)
   );

   AST_NO_WRITE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && wr_b && same_row) |-> (((dmask_a & dmask_b) == '0) && ((pmask_a & pmask_b) == '0))); // R7

   AST_WRITE_FIRST_A: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a && we_a) |=> (dout_a == $past(din_a))); // R3

   AST_WRITE_FIRST_B: assert property (@(posedge clk) disable iff (!rst_n)
      (en_b && we_b) |=> (dout_b == $past(din_b))); // R3

   AST_IDLE_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
      !en_a |=> ($stable(dout_a) && $stable(pout_a))); // R4

   AST_IDLE_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
      !en_b |=> ($stable(dout_b) && $stable(pout_b))); // R4

   AST_READBACK_A: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a && !we_a && $past(en_a && we_a) && (addr_a == $past(addr_a)))
      |=> (dout_a == $past(din_a, 2))); // R2

   AST_READBACK_B: assert property (@(posedge clk) disable iff (!rst_n)
      (en_b && !we_b && $past(en_b && we_b) && (addr_b == $past(addr_b)))
      |=> (dout_b == $past(din_b, 2))); // R2
endmodule

// File: tb/tdp_shape_ram_tb.sv
module tdp_shape_ram_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // main instance: 9-bit port A, 36-bit port B
   logic        en_a = 0, we_a = 0, en_b = 0, we_b = 0;
   logic [10:0] addr_a = '0;
   logic [7:0]  din_a = '0;
   logic [0:0]  pin_a = '0;
   logic [8:0]  addr_b = '0;
   logic [31:0] din_b = '0;
   logic [3:0]  pin_b = '0;
   logic [7:0]  dout_a;
   logic [0:0]  pout_a;
   logic [31:0] dout_b;
   logic [3:0]  pout_b;

   tdp_shape_ram #(.WIDTH_A(9), .WIDTH_B(36)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a), .pin_a(pin_a),
      .dout_a(dout_a), .pout_a(pout_a),
      .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b), .pin_b(pin_b),
      .dout_b(dout_b), .pout_b(pout_b)
   );

   // narrow instance: 2-bit port A, 4-bit port B
   logic        n_ea = 0, n_wa = 0, n_eb = 0, n_wb = 0;
   logic [12:0] n_aa = '0;
   logic [11:0] n_ab = '0;
   logic [1:0]  n_da = '0;
   logic [3:0]  n_db = '0;
   logic [0:0]  n_pa = 1'b1, n_pb = 1'b1;
   logic [1:0]  n_qa;
   logic [3:0]  n_qb;
   logic [0:0]  n_ra, n_rb;

   tdp_shape_ram #(.WIDTH_A(2), .WIDTH_B(4)) u_nar (
      .clk(clk), .rst_n(rst_n),
      .en_a(n_ea), .we_a(n_wa), .addr_a(n_aa), .din_a(n_da), .pin_a(n_pa),
      .dout_a(n_qa), .pout_a(n_ra),
      .en_b(n_eb), .we_b(n_wb), .addr_b(n_ab), .din_b(n_db), .pin_b(n_pb),
      .dout_b(n_qb), .pout_b(n_rb)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model of the shared array
   logic [16383:0] m_d;
   logic [2047:0]  m_p;

   typedef struct {
      logic [31:0] d;
      logic [3:0]  p;
      string       tag;
   } exp_t;

   exp_t qa[$];
   exp_t qb[$];
   exp_t last_a = '{d: 32'h0, p: 4'h0, tag: "R9"};
   exp_t last_b = '{d: 32'h0, p: 4'h0, tag: "R9"};

   // driver: drive both ports for one cycle, push expected outputs
   task automatic step(input logic ea, input logic wa, input int aa, input logic [7:0] da,
                       input logic pa, input string ta,
                       input logic eb, input logic wb, input int ab, input logic [31:0] db,
                       input logic [3:0] pb, input string tb);
      exp_t xa, xb;
      @(negedge clk);
      en_a = ea; we_a = wa; addr_a = 11'(aa); din_a = da; pin_a = pa;
      en_b = eb; we_b = wb; addr_b = 9'(ab); din_b = db; pin_b = pb;
      xa = last_a;
      xb = last_b;
      if (ea) begin
         if (wa) begin xa.d = {24'h0, da}; xa.p = {3'b0, pa}; end
         else begin xa.d = {24'h0, m_d[aa*8 +: 8]}; xa.p = {3'b0, m_p[aa]}; end
      end
      if (eb) begin
         if (wb) begin xb.d = db; xb.p = pb; end
         else begin xb.d = m_d[ab*32 +: 32]; xb.p = m_p[ab*4 +: 4]; end
      end
      xa.tag = ea ? ta : "R4 idle A";
      xb.tag = eb ? tb : "R4 idle B";
      qa.push_back(xa);
      qb.push_back(xb);
      last_a = xa;
      last_b = xb;
      if (ea && wa) begin m_d[aa*8 +: 8] = da; m_p[aa] = pa; end
      if (eb && wb) begin m_d[ab*32 +: 32] = db; m_p[ab*4 +: 4] = pb; end
   endtask

   // monitor: compare outputs a little after each edge
   always @(posedge clk) begin
      #2;
      if (qa.size() > 0) begin
         exp_t e;
         e = qa.pop_front();
         check({e.tag, " port A"}, {4'(pout_a), 32'(dout_a)}, {e.p, e.d});
      end
      if (qb.size() > 0) begin
         exp_t e;
         e = qb.pop_front();
         check({e.tag, " port B"}, {pout_b, dout_b}, {e.p, e.d});
      end
   end

   initial begin
      #1_000_000;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      m_d = '0;
      m_p = '0;
      repeat (3) @(posedge clk);
      #2;
      check("R9 reset dout_a", 36'(dout_a), 36'h0);
      check("R9 reset dout_b", {pout_b, dout_b}, 36'h0);
      check("R9 reset narrow", {n_ra, n_rb, n_qa, n_qb}, 36'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // fill rows 0..15 through port B
      for (int r = 0; r < 16; r++)
         step(0, 0, 0, 8'h0, 0, "", 1, 1, r, 32'h1357_0000 + 32'(r * 32'h0101), 4'(r), "R3 fill");

      // R5/R6: wide write, narrow reads of the same row
      step(0, 0, 0, 8'h0, 0, "", 1, 1, 3, 32'h89AB_CDEF, 4'hA, "R3 wide write");
      for (int n = 12; n < 16; n++)
         step(1, 0, n, 8'h0, 0, "R5 R6 byte lane read", 0, 0, 0, 32'h0, 4'h0, "");

      // R8: A writes a byte of row 3 while B reads row 3; then B sees the merge
      step(1, 1, 14, 8'h11, 1, "R3 narrow write", 1, 0, 3, 32'h0, 4'h0, "R8 old data");
      step(0, 0, 0, 8'h0, 0, "", 1, 0, 3, 32'h0, 4'h0, "R5 R6 merged row");

      // R4: enable low with write-enable high changes nothing
      step(0, 1, 12, 8'hFF, 1, "", 0, 1, 3, 32'hFFFF_FFFF, 4'hF, "");
      step(1, 0, 12, 8'h0, 0, "R4 no write A", 1, 0, 3, 32'h0, 4'h0, "R4 no write B");

      // R7: both ports write in one cycle, then cross reads
      step(1, 1, 20, 8'h5A, 0, "R7 dual write A", 1, 1, 6, 32'hCAFE_F00D, 4'h5, "R7 dual write B");
      step(1, 0, 24, 8'h0, 0, "R7 A reads B row", 1, 0, 5, 32'h0, 4'h0, "R7 B reads A byte");
      step(1, 0, 20, 8'h0, 0, "R2 readback", 0, 0, 0, 32'h0, 4'h0, "");

      // mixed traffic within rows 0..15, no overlapping writes
      lf = 16'hACE1;
      for (int i = 0; i < 60; i++) begin
         logic wa, wb, eb;
         int aa, ab;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         wa = lf[0];
         eb = lf[1] | lf[2];
         wb = lf[3];
         aa = int'(lf[9:4]);
         ab = int'(lf[13:10]);
         if (wa && wb && eb && (aa / 4 == ab)) wb = 1'b0;
         step(1, wa, aa, lf[15:8], lf[5], wa ? "R3 mix" : "R2 mix",
              eb, wb, ab, {lf, ~lf}, lf[7:4], wb ? "R3 mix" : "R2 mix");
      end
      step(0, 0, 0, 8'h0, 0, "", 0, 0, 0, 32'h0, 4'h0, "");
      repeat (2) @(posedge clk);

      // narrow instance: same-row dual write, cross-width reads, zero parity
      @(negedge clk);
      n_ea = 1; n_wa = 1; n_aa = 13'd0; n_da = 2'b10;
      n_eb = 1; n_wb = 1; n_ab = 12'd1; n_db = 4'hC;
      @(posedge clk); #2;
      check("R3 narrow A write-first", 36'(n_qa), 36'h2);
      check("R3 narrow B write-first", 36'(n_qb), 36'hC);
      @(negedge clk);
      n_aa = 13'd1; n_da = 2'b01;
      n_wb = 0; n_ab = 12'd1;
      @(posedge clk); #2;
      check("R7 narrow same-row B kept", 36'(n_qb), 36'hC);
      @(negedge clk);
      n_wa = 0; n_aa = 13'd3;
      n_ab = 12'd0;
      @(posedge clk); #2;
      check("R5 narrow A reads B bits", 36'(n_qa), 36'h3);
      check("R7 narrow B sees both A writes", 36'(n_qb), 36'h6);
      check("R1 narrow parity zero", {n_ra, n_rb}, 36'h0);
      @(negedge clk);
      n_ea = 0; n_eb = 0;
      repeat (2) @(posedge clk);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule